// File: doc/BRIEF.md
# Shared-Pin PWM DAC Bank

The block holds thirteen 8-bit pulse-width channels behind a small CPU register window. All channels compare one shared 8-bit phase counter against their own duty code. The counter advances only on cycles where the count-tick input is high. Software writes a duty code into a channel's register at any time. The waveform adopts that code only when the phase counter rolls over from 255 to 0, so a frame is never cut short or stretched.

Seven channels own their pins outright. The other six share pins with general-purpose port bits. A six-bit ownership register decides which function drives each shared pin: a bit written 0 hands the pin to the PWM wave, and a bit left at 1 keeps the port output latch on the pin. Each pin leaves the block as a logic level plus a pull-low enable, which suits an open-drain pad outside the block.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset, every duty register reads 80H. The ownership register holds all ones, so each shared pin shows its port latch bit. The phase counter starts at 0.
- R2: Channel n (0..6) is read and written at address 30H+n. Channel n (7..12) is at 38H+(n-7). A read returns the last value written.
- R3: Writes to address 37H, or to any address outside 30H..3DH other than 0FH, change no duty register. Reads at such addresses return 00H.
- R4: A channel's wave is high exactly while the phase is below its active duty code. A code of 00H gives a constant low, and FFH gives 255 high phases out of every 256.
- R5: The phase counter advances by one only on a cycle with cnt_tick high, and it wraps from 255 to 0. With cnt_tick low it holds.
- R6: A written duty code becomes the active code only at the clock edge where the phase wraps from 255 to 0. It never takes effect mid-frame.
- R7: Writing address 0FH sets ownership bit k from bus_wdata[k] (k = 0..5) for shared channel 7+k, and bits 7..6 are ignored. Bit 0 hands the pin to the PWM wave. Bit 1 puts port_latch[k] on the pin.
- R8: Channels 0..6 always drive their pins with their PWM wave.
- R9: pin_pull_low is the complement of pin_level on every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Phase counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| port_latch | input | 6 | Port output latch bits for the shared pins |
| pin_level | output | 13 | Logic level of each pin |
| pin_pull_low | output | 13 | Pull-low enable of each pin |

## Verification
Several rules are checked by assertions on every cycle. These are the phase counter's hold-or-increment behaviour, the stability of the active duty codes away from the frame boundary, the constant low for a zero code, the near-full high for FFH, and the routing of waves and latch bits onto the pins. Only the bench's scenarios can show the rest. That covers the address decoding and read-back, writes to the gap and to foreign addresses being ignored, the reset values, and the exact high-phase count per frame for every duty code. The bench reaches these through a sweep where each channel meets all 256 codes and the ownership register meets all 64 patterns.

// File: rtl/pwmb_pkg.sv
// Package: shared constants and address helper for the PWM DAC bank.
// Assumes an 8-bit register address space with duty registers laid out
// from DUTY_BASE upward, skipping the single gap address after the
// dedicated channels.
package pwmb_pkg;
    localparam int DUTY_W     = 8;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] DUTY_BASE  = 8'h30;
    localparam logic [ADDR_W-1:0] OWNER_ADDR = 8'h0F;
    localparam logic [DUTY_W-1:0] RESET_DUTY = 8'h80;

    typedef logic [DUTY_W-1:0] duty_t;

    // Address of channel idx; shared channels sit one slot past the gap.
    function automatic logic [ADDR_W-1:0] ch_addr(input int idx, input int n_ded);
        int a;
        a = int'(DUTY_BASE) + idx + ((idx >= n_ded) ? 1 : 0);
        return ADDR_W'(a);
    endfunction
endpackage

// File: rtl/pwmb_phase.sv
// Module: shared phase counter. Advances on tick and wraps at all-ones.
// wrap is high on the cycle whose tick moves the phase from max to 0.
module pwmb_phase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] phase,
    output logic         wrap
);
    localparam logic [W-1:0] PH_MAX = '1;

    // Frame boundary: the tick that rolls the counter over.
    assign wrap = tick && (phase == PH_MAX);

    // Phase register: hold without tick, increment with it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pwmb_regs.sv
// Module: register window. Decodes duty registers and the ownership
// register, and returns read data combinationally. Assumes single-cycle
// writes with address and data valid alongside wr.
module pwmb_regs
    import pwmb_pkg::*;
#(
    parameter int NUM_CH  = 13,
    parameter int NUM_DED = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DUTY_W-1:0]               wdata,
    output logic [DUTY_W-1:0]               rdata,
    output logic [NUM_CH-1:0][DUTY_W-1:0]   duty,
    output logic [NUM_CH-NUM_DED-1:0]       owner_n
);
    localparam int NUM_SHR = NUM_CH - NUM_DED;

    duty_t             duty_mem [NUM_CH];
    logic [NUM_CH-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_duty
            localparam logic [ADDR_W-1:0] MY_ADDR = ch_addr(gi, NUM_DED);
            assign hit[gi] = (addr == MY_ADDR);

            // Duty register for one channel.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    duty_mem[gi] <= RESET_DUTY;
                else if (wr && hit[gi])
                    duty_mem[gi] <= wdata;
            end

            assign duty[gi] = duty_mem[gi];
        end
    endgenerate

    // Ownership register: active-low per shared channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_n <= '1;
        else if (wr && (addr == OWNER_ADDR))
            owner_n <= wdata[NUM_SHR-1:0];
    end

    // Read mux: the matching duty register, zero elsewhere.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (hit[i])
                rdata = duty_mem[i];
    end
endmodule

// File: rtl/pwmb_chan.sv
// Module: one PWM channel. Holds the active duty code, reloaded from the
// written code only at a frame boundary, and compares it with the phase.
module pwmb_chan
    import pwmb_pkg::*;
#(
    parameter int W = DUTY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    input  logic [W-1:0] duty_next,
    input  logic [W-1:0] phase,
    output logic [W-1:0] act,
    output logic         wave
);
    // Active code: adopt the written code as the phase rolls to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= W'(RESET_DUTY);
        else if (wrap)
            act <= duty_next;
    end

    // High while the phase is below the active code.
    assign wave = (phase < act);
endmodule

// File: rtl/pwm_dac_bank.sv
// Module: top of the PWM DAC bank. Dedicated channels drive their pins
// directly; shared channels drive theirs only when their active-low
// ownership bit is cleared, else the port latch bit is passed through.
// Pins leave as a level plus a pull-low enable for an open-drain pad.
module pwm_dac_bank
    import pwmb_pkg::*;
#(
    parameter int NUM_CH  = 13,
    parameter int NUM_DED = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_tick,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DUTY_W-1:0]           bus_wdata,
    output logic [DUTY_W-1:0]           bus_rdata,
    input  logic [NUM_CH-NUM_DED-1:0]   port_latch,
    output logic [NUM_CH-1:0]           pin_level,
    output logic [NUM_CH-1:0]           pin_pull_low
);
    localparam int NUM_SHR = NUM_CH - NUM_DED;

    logic [DUTY_W-1:0]             phase;
    logic                          wrap;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    logic [NUM_CH-1:0][DUTY_W-1:0] act_duty;
    logic [NUM_CH-1:0]             wave;
    logic [NUM_SHR-1:0]            owner_n;

    pwmb_phase #(.W(DUTY_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cnt_tick),
        .phase (phase),
        .wrap  (wrap)
    );

    pwmb_regs #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .duty    (duty),
        .owner_n (owner_n)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            pwmb_chan #(.W(DUTY_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wrap      (wrap),
                .duty_next (duty[gi]),
                .phase     (phase),
                .act       (act_duty[gi]),
                .wave      (wave[gi])
            );

            if (gi < NUM_DED) begin : g_ded
                assign pin_level[gi] = wave[gi];
            end else begin : g_shr
                assign pin_level[gi] = owner_n[gi-NUM_DED] ? port_latch[gi-NUM_DED]
                                                           : wave[gi];
            end
        end
    endgenerate

    assign pin_pull_low = ~pin_level;
endmodule

// File: rtl/pwmb_chk.sv
// Module: assertion checker for pwm_dac_bank, attached with bind.
// Observes the phase counter, active duty codes, waves and pins.
module pwmb_chk #(
    parameter int NUM_CH  = 13,
    parameter int NUM_DED = 7,
    parameter int W       = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic [W-1:0]             phase,
    input logic [NUM_CH-1:0][W-1:0] act_duty,
    input logic [NUM_CH-1:0]        wave,
    input logic [NUM_CH-NUM_DED-1:0] owner_n,
    input logic [NUM_CH-NUM_DED-1:0] port_latch,
    input logic [NUM_CH-1:0]        pin_level
);
    localparam logic [W-1:0] ALL1 = '1;

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == W'($past(phase) + 1'b1)));

    assert_act_frame_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(act_duty));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (act_duty[gi] == '0) |-> !wave[gi]);
            assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ((act_duty[gi] == ALL1) && (phase != ALL1)) |-> wave[gi]);
            if (gi < NUM_DED) begin : g_ded
                assert_ded_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    pin_level[gi] == wave[gi]);
            end else begin : g_shr
                assert_shr_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    owner_n[gi-NUM_DED] |-> (pin_level[gi] == port_latch[gi-NUM_DED]));
                assert_shr_pwm_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    !owner_n[gi-NUM_DED] |-> (pin_level[gi] == wave[gi]));
            end
        end
    endgenerate
endmodule

bind pwm_dac_bank pwmb_chk #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .W(pwmb_pkg::DUTY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_tick),
    .phase      (phase),
    .act_duty   (act_duty),
    .wave       (wave),
    .owner_n    (owner_n),
    .port_latch (port_latch),
    .pin_level  (pin_level)
);

// File: tb/tb_pwm_dac_bank.sv
// Bench: sweeps every duty code on every channel and every ownership
// pattern, comparing pins and read data against an arithmetic model.
module tb_pwm_dac_bank;
    localparam int NCH  = 13;
    localparam int NDED = 7;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cnt_tick = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] port_latch = 6'b101010;
    logic [12:0] pin_level;
    logic [12:0] pin_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mduty [NCH];
    int mact  [NCH];
    int hc    [NCH];
    int mphase = 0;
    logic [5:0] mown = 6'h3F;
    bit frame_full = 0;

    always #2 clk = ~clk;

    pwm_dac_bank dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .port_latch(port_latch),
        .pin_level(pin_level), .pin_pull_low(pin_pull_low)
    );

    function automatic int addr_of(input int ch);
        return (ch < NDED) ? 8'h30 + ch : 8'h38 + ch - NDED;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h phase=%0d", req, act, exp, mphase);
        end
    endtask

    // Compare every pin against the model; count high phases per frame.
    task automatic check_pins(input bit ticked, input bit wrapped);
        if (ticked && wrapped) begin
            frame_full = 1;
            for (int c = 0; c < NDED; c++) hc[c] = 0;
        end
        for (int c = 0; c < NCH; c++) begin
            int e;
            if (c >= NDED && mown[c-NDED])
                e = int'(port_latch[c-NDED]);
            else
                e = (mphase < mact[c]) ? 1 : 0;
            chk((c < NDED) ? "R8/R4 pin" : "R7 pin", int'(pin_level[c]), e);
            chk("R9 pull_low", int'(pin_pull_low[c]), 1 - e);
            if (ticked && c < NDED && pin_level[c]) hc[c]++;
        end
        if (ticked && mphase == 255 && frame_full) begin
            for (int c = 0; c < NDED; c++) chk("R4 high count", hc[c], mact[c]);
            frame_full = 0;
        end
    endtask

    task automatic step(input bit t);
        bit w;
        w = 0;
        @(negedge clk);
        cnt_tick = t;
        bus_wr = 0;
        @(posedge clk);
        if (t) begin
            if (mphase == 255) begin
                mphase = 0;
                for (int c = 0; c < NCH; c++) mact[c] = mduty[c];
                w = 1;
            end else mphase++;
        end
        #1;
        check_pins(t, w);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cnt_tick = 0;
        bus_wr = 1;
        bus_addr = 8'(a);
        bus_wdata = 8'(d);
        @(posedge clk);
        for (int c = 0; c < NCH; c++)
            if (a == addr_of(c)) mduty[c] = d & 255;
        if (a == 8'h0F) mown = 6'(d);
        #1;
        check_pins(0, 0);
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        cnt_tick = 0;
        bus_wr = 0;
        bus_addr = 8'(a);
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            mduty[c] = 8'h80; mact[c] = 8'h80; hc[c] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state on pins and in registers
        check_pins(0, 0);
        for (int c = 0; c < NCH; c++) rd(addr_of(c), 8'h80, "R1 reset duty");

        // R2: map and read-back; R6: active codes unchanged without a wrap
        for (int c = 0; c < NCH; c++) wr(addr_of(c), (c * 17 + 3) & 255);
        for (int c = 0; c < NCH; c++) rd(addr_of(c), (c * 17 + 3) & 255, "R2 readback");

        // R3: gap and foreign addresses ignored, read as zero
        wr(8'h37, 8'h5A); wr(8'h3E, 8'hA5); wr(8'h2F, 8'h11); wr(8'h0E, 8'h22);
        for (int c = 0; c < NCH; c++) rd(addr_of(c), (c * 17 + 3) & 255, "R3 no side effect");
        rd(8'h37, 0, "R3 gap read"); rd(8'h3E, 0, "R3 foreign read");

        // R6: mid-frame rewrite; R5: hold without tick
        for (int i = 0; i < 100; i++) step(1);
        wr(addr_of(0), 8'h00); wr(addr_of(3), 8'hFF);
        for (int i = 0; i < 20; i++) step(0);
        for (int i = 0; i < 600; i++) step((i % 3) != 1);

        // Sweep: all codes per channel, all ownership patterns
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < NCH; c++) wr(addr_of(c), (v + c * 19) & 255);
            wr(8'h0F, (v & 63) | 8'hC0);
            @(negedge clk);
            port_latch = 6'(v >> 2);
            for (int i = 0; i < 256; i++) step(1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule